// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the digital side of a bank of analog comparators. Each comparator's raw output bit is brought into the system clock domain. The synchronized level is sampled on a sampling enable. An event is then detected between two consecutive samples. Each comparator selects its own event: any change of level, only a falling edge, or only a rising edge. An event sets a sticky flag for that comparator, and the flag drives an interrupt request when the comparator's enable bit is set.

Software programs each comparator through a shared set of write-data inputs and a per-comparator write strobe. The write carries the interrupt enable, the two-bit event code and a three-bit negative-input select code. The block only stores that select code and drives it out to the analog side. A single status word combines four things: the sampling-rate control, every flag, a constant zero bit and the sampled output levels. Writing the status word sets the sampling-rate control. Flags are cleared by writing a one to them, or by a one-cycle acknowledge pulse when the interrupt is serviced. When the sampling-rate control is set, the comparators are sampled on every second system clock.

Top module: `cmp_evt_irq`

## Requirements
- R1: After synchronous reset, `stat_rdata`, `irq` and `nsel_out` are all zero.
- R2: Event code 2'b00 sets the comparator's flag on a sampled rising edge and on a sampled falling edge.
- R3: Event code 2'b10 sets the flag on a sampled falling edge (1 to 0) and never on a rising edge.
- R4: Event code 2'b11 sets the flag on a sampled rising edge (0 to 1) and never on a falling edge.
- R5: Event code 2'b01 is reserved and never sets the flag, for either edge.
- R6: `irq[i]` is high exactly when flag i is set and the enable of comparator i is set. A flag whose enable is clear is still visible in the status word.
- R7: A one-cycle pulse on `irq_ack[i]` clears flag i.
- R8: A status write with a one in a flag bit clears that flag. A zero in a flag bit leaves that flag unchanged.
- R9: When an event and a clear (acknowledge or write-one) act on the same flag in the same cycle, the flag ends up set.
- R10: Status layout for three comparators: bit 7 is the sampling-rate control (written through bit 7 of a status write), bits 6..4 are the flags of comparators 2..0, bit 3 reads 0, and bits 2..0 are the sampled levels of comparators 2..0.
- R11: With bit 7 set, comparators are sampled every second cycle. A raw input that alternates every cycle is then always seen at the same value, produces no toggle event and leaves its level bit unchanged. With bit 7 clear, the same input sets the toggle flag.
- R12: Comparator i's 3-bit select code appears on `nsel_out[3i+2:3i]` after its write. Reserved codes 3'b110 and 3'b111 are stored as written.
- R13: With bit 7 clear, a raw level change becomes visible in the status level bits after the third rising clock edge, and not after the second.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | NCMP | Raw comparator output bits, asynchronous |
| ctl_we | input | NCMP | Per-comparator control write strobe |
| ctl_ie | input | 1 | Interrupt enable written by `ctl_we` |
| ctl_sens | input | 2 | Event code written by `ctl_we` |
| ctl_nsel | input | 3 | Negative-input select code written by `ctl_we` |
| stat_we | input | 1 | Status word write strobe |
| stat_wdata | input | 2*NCMP+2 | Status write data: rate control, write-one-to-clear flags |
| irq_ack | input | NCMP | One-cycle interrupt acknowledge per comparator |
| irq | output | NCMP | Interrupt request per comparator |
| stat_rdata | output | 2*NCMP+2 | Packed status word |
| nsel_out | output | 3*NCMP | Stored select codes, comparator 0 in the low bits |

## Verification
Two functions can act on one flag in the same cycle: setting it on a detected event, and clearing it by acknowledge or by a write of one. The bench counts clock edges from a raw input change, so that the event is detected on exactly the edge where the acknowledge pulse, or a status write with a one in that flag's bit, is also active. It judges the result by the flag bit in the status word after that edge, which must still read one. A plain clear in a quiet cycle then confirms that each clear path works on its own.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

    localparam int NSEL_W = 3;

    typedef enum logic [1:0] {
        SENS_ANY  = 2'b00,
        SENS_RSVD = 2'b01,
        SENS_FALL = 2'b10,
        SENS_RISE = 2'b11
    } sens_e;

    typedef struct packed {
        logic              ie;
        sens_e             sens;
        logic [NSEL_W-1:0] nsel;
    } cmp_ctl_t;

    // True when the transition old -> cur matches the selected event kind
    function automatic logic event_hit(sens_e s, logic old_v, logic cur_v);
        logic hit;
        unique case (s)
            SENS_ANY:  hit = old_v ^ cur_v;
            SENS_FALL: hit = old_v & ~cur_v;
            SENS_RISE: hit = ~old_v & cur_v;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cmp_sample_tick.sv
module cmp_sample_tick (
    input  logic clk,
    input  logic rst,
    input  logic half_rate,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)            phase_q <= 1'b0;
        else if (half_rate) phase_q <= ~phase_q;
        else                phase_q <= 1'b0;
    end

    assign tick = ~half_rate | phase_q;
endmodule

// File: rtl/cmp_edge_chan.sv
module cmp_edge_chan
    import cmp_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  raw,
    input  sens_e sens,
    input  logic  clr,
    output logic  evt,
    output logic  flag,
    output logic  level
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_q;
    logic                   flag_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            end
        end
    endgenerate

    assign evt = tick & event_hit(sens, level_q, sync_q[TOP]);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (tick) level_q <= sync_q[TOP];
            flag_q <= evt | (flag_q & ~clr);
        end
    end

    assign flag  = flag_q;
    assign level = level_q;
endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
    import cmp_evt_pkg::*;
#(
    parameter int NCMP        = 3,
    parameter int SYNC_STAGES = 2,
    localparam int STAT_W     = 2 * NCMP + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCMP-1:0]        cmp_raw,
    input  logic [NCMP-1:0]        ctl_we,
    input  logic                   ctl_ie,
    input  logic [1:0]             ctl_sens,
    input  logic [NSEL_W-1:0]      ctl_nsel,
    input  logic                   stat_we,
    input  logic [STAT_W-1:0]      stat_wdata,
    input  logic [NCMP-1:0]        irq_ack,
    output logic [NCMP-1:0]        irq,
    output logic [STAT_W-1:0]      stat_rdata,
    output logic [NCMP*NSEL_W-1:0] nsel_out
);
    localparam int FLAG_LSB = NCMP + 1;
    localparam int DIV_BIT  = STAT_W - 1;

    cmp_ctl_t        ctl_q [NCMP];
    logic            half_rate_q;
    logic            tick;
    logic [NCMP-1:0] evt;
    logic [NCMP-1:0] flag_q;
    logic [NCMP-1:0] level_q;
    logic [NCMP-1:0] clr;
    logic [NCMP-1:0] ie_vec;
    logic [2*NCMP-1:0] sens_vec;

    always_ff @(posedge clk) begin
        if (rst)          half_rate_q <= 1'b0;
        else if (stat_we) half_rate_q <= stat_wdata[DIV_BIT];
    end

    cmp_sample_tick u_tick (
        .clk      (clk),
        .rst      (rst),
        .half_rate(half_rate_q),
        .tick     (tick)
    );

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)            ctl_q[i] <= '0;
                else if (ctl_we[i]) ctl_q[i] <= '{ie: ctl_ie, sens: sens_e'(ctl_sens), nsel: ctl_nsel};
            end

            assign clr[i] = irq_ack[i] | (stat_we & stat_wdata[FLAG_LSB+i]);

            cmp_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
                .clk  (clk),
                .rst  (rst),
                .tick (tick),
                .raw  (cmp_raw[i]),
                .sens (ctl_q[i].sens),
                .clr  (clr[i]),
                .evt  (evt[i]),
                .flag (flag_q[i]),
                .level(level_q[i])
            );

            assign ie_vec[i]                   = ctl_q[i].ie;
            assign sens_vec[2*i +: 2]          = ctl_q[i].sens;
            assign irq[i]                      = flag_q[i] & ctl_q[i].ie;
            assign nsel_out[NSEL_W*i +: NSEL_W] = ctl_q[i].nsel;
        end
    endgenerate

    assign stat_rdata = {half_rate_q, flag_q, 1'b0, level_q};
endmodule

// File: rtl/cmp_evt_irq_chk.sv
module cmp_evt_irq_chk #(
    parameter int NCMP   = 3,
    parameter int STAT_W = 2 * NCMP + 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NCMP-1:0]   irq,
    input logic [NCMP-1:0]   irq_ack,
    input logic              stat_we,
    input logic [STAT_W-1:0] stat_wdata,
    input logic [STAT_W-1:0] stat_rdata,
    input logic [NCMP-1:0]   evt,
    input logic [NCMP-1:0]   ie_vec,
    input logic [2*NCMP-1:0] sens_vec
);
    localparam int FL = NCMP + 1;

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_a
            assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (rst)
                irq[i] |-> stat_rdata[FL+i]);
            assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
                !ie_vec[i] |-> !irq[i]);
            assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (rst)
                (sens_vec[2*i +: 2] == 2'b01) |-> !evt[i]);
            assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
                (irq_ack[i] && !evt[i]) |=> !stat_rdata[FL+i]);
            assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
                (stat_we && stat_wdata[FL+i] && !evt[i]) |=> !stat_rdata[FL+i]);
            assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> stat_rdata[FL+i]);
            assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
                (!evt[i] && !irq_ack[i] && !(stat_we && stat_wdata[FL+i]))
                    |=> $stable(stat_rdata[FL+i]));
        end
    endgenerate
endmodule

bind cmp_evt_irq cmp_evt_irq_chk #(.NCMP(NCMP), .STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .irq_ack   (irq_ack),
    .stat_we   (stat_we),
    .stat_wdata(stat_wdata),
    .stat_rdata(stat_rdata),
    .evt       (evt),
    .ie_vec    (ie_vec),
    .sens_vec  (sens_vec)
);

// File: tb/sim_cmp_evt_irq.sv
module sim_cmp_evt_irq;
    localparam int CLK_PERIOD = 10;
    localparam int NCMP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmp_raw = '0;
    logic [2:0] ctl_we = '0;
    logic       ctl_ie = 1'b0;
    logic [1:0] ctl_sens = '0;
    logic [2:0] ctl_nsel = '0;
    logic       stat_we = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic [2:0] irq_ack = '0;
    logic [2:0] irq;
    logic [7:0] stat_rdata;
    logic [8:0] nsel_out;

    int checks = 0;
    int failures = 0;
    logic divb = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_evt_irq #(.NCMP(NCMP)) u0 (
        .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .ctl_we(ctl_we), .ctl_ie(ctl_ie),
        .ctl_sens(ctl_sens), .ctl_nsel(ctl_nsel), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .irq_ack(irq_ack), .irq(irq),
        .stat_rdata(stat_rdata), .nsel_out(nsel_out)
    );

    typedef struct packed {
        logic [1:0] sens;
        logic       from_v;
        logic       to_v;
        logic       exp_flag;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 1'b0, 1'b1, 1'b1},
        '{2'b00, 1'b1, 1'b0, 1'b1},
        '{2'b10, 1'b1, 1'b0, 1'b1},
        '{2'b10, 1'b0, 1'b1, 1'b0},
        '{2'b11, 1'b0, 1'b1, 1'b1},
        '{2'b11, 1'b1, 1'b0, 1'b0},
        '{2'b01, 1'b0, 1'b1, 1'b0},
        '{2'b01, 1'b1, 1'b0, 1'b0}
    };

    function automatic string sens_tag(logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b10:   return "R3";
            2'b11:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_ctl(int idx, logic ie, logic [1:0] s, logic [2:0] n);
        ctl_we = '0;
        ctl_we[idx] = 1'b1;
        ctl_ie = ie; ctl_sens = s; ctl_nsel = n;
        step();
        ctl_we = '0;
    endtask

    task automatic wr_stat(logic [7:0] d);
        stat_we = 1'b1;
        stat_wdata = d;
        step();
        stat_we = 1'b0;
        stat_wdata = '0;
    endtask

    task automatic clear_all();
        wr_stat({divb, 3'b111, 4'b0000});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(2);
        rst = 1'b0;
        // R1: reset state
        check("R1 status", stat_rdata, 8'h00);
        check("R1 irq", irq, 3'b000);
        check("R1 nsel", nsel_out, 9'h000);

        // Vector table on comparator 0: R2..R5
        foreach (VECS[k]) begin
            wr_ctl(0, 1'b1, VECS[k].sens, 3'b000);
            cmp_raw[0] = VECS[k].from_v;
            step(5);
            clear_all();
            cmp_raw[0] = VECS[k].to_v;
            step(5);
            check({sens_tag(VECS[k].sens), " flag"}, stat_rdata[4], VECS[k].exp_flag);
            check({sens_tag(VECS[k].sens), " irq"}, irq[0], VECS[k].exp_flag);
        end
        cmp_raw[0] = 1'b0;
        wr_ctl(0, 1'b0, 2'b01, 3'b000);
        step(5);
        clear_all();

        // R13: synchronizer latency
        cmp_raw[2] = 1'b1;
        step(2);
        check("R13 before third edge", stat_rdata[2], 1'b0);
        step();
        check("R13 after third edge", stat_rdata[2], 1'b1);
        cmp_raw[2] = 1'b0;
        step(5);

        // R6: flag without enable, then enable
        wr_ctl(1, 1'b0, 2'b11, 3'b101);
        cmp_raw[1] = 1'b1;
        step(5);
        check("R6 flag set while disabled", stat_rdata[5], 1'b1);
        check("R6 irq low while disabled", irq[1], 1'b0);
        wr_ctl(1, 1'b1, 2'b11, 3'b101);
        check("R6 irq after enable", irq[1], 1'b1);

        // R7: acknowledge clears
        irq_ack[1] = 1'b1;
        step();
        irq_ack[1] = 1'b0;
        check("R7 flag after ack", stat_rdata[5], 1'b0);
        check("R7 irq after ack", irq[1], 1'b0);

        // R8: write zero no effect, write one clears
        wr_ctl(2, 1'b1, 2'b00, 3'b110);
        cmp_raw[2] = 1'b1;
        step(5);
        check("R8 flag set", stat_rdata[6], 1'b1);
        wr_stat({divb, 3'b011, 4'b0000});
        check("R8 zero leaves flag", stat_rdata[6], 1'b1);
        wr_stat({divb, 3'b100, 4'b0000});
        check("R8 one clears flag", stat_rdata[6], 1'b0);

        // R12: select codes stored, including reserved
        wr_ctl(0, 1'b0, 2'b01, 3'b111);
        check("R12 nsel", nsel_out, {3'b110, 3'b101, 3'b111});

        // R10: packing with levels 2,1 high and 0 low, no flags
        check("R10 status pack", stat_rdata, 8'b0000_0110);

        // R9: event coincides with write-one-to-clear
        wr_ctl(0, 1'b1, 2'b00, 3'b111);
        cmp_raw[0] = 1'b1;
        step(5);
        cmp_raw[0] = 1'b0;
        step(2);
        wr_stat({divb, 3'b001, 4'b0000});
        check("R9 event beats write clear", stat_rdata[4], 1'b1);
        // R9: event coincides with acknowledge
        cmp_raw[0] = 1'b1;
        step(2);
        irq_ack[0] = 1'b1;
        step();
        irq_ack[0] = 1'b0;
        check("R9 event beats ack", stat_rdata[4], 1'b1);
        irq_ack[0] = 1'b1;
        step();
        irq_ack[0] = 1'b0;
        check("R7 quiet ack clears", stat_rdata[4], 1'b0);

        // R11: half-rate sampling hides per-cycle alternation
        divb = 1'b1;
        wr_stat(8'h80);
        check("R10 rate bit readback", stat_rdata[7], 1'b1);
        for (int t = 0; t < 8; t++) begin
            cmp_raw[0] = ~cmp_raw[0];
            step();
        end
        stat_we = 1'b1; stat_wdata = 8'hF0;
        cmp_raw[0] = ~cmp_raw[0];
        step();
        stat_we = 1'b0; stat_wdata = '0;
        begin
            logic lvl0;
            lvl0 = stat_rdata[0];
            for (int t = 0; t < 12; t++) begin
                cmp_raw[0] = ~cmp_raw[0];
                step();
            end
            check("R11 no event at half rate", stat_rdata[4], 1'b0);
            check("R11 level steady at half rate", stat_rdata[0], lvl0);
        end
        divb = 1'b0;
        stat_we = 1'b1; stat_wdata = 8'h00;
        cmp_raw[0] = ~cmp_raw[0];
        step();
        stat_we = 1'b0;
        for (int t = 0; t < 6; t++) begin
            cmp_raw[0] = ~cmp_raw[0];
            step();
        end
        check("R11 event at full rate", stat_rdata[4], 1'b1);
        check("R10 rate bit cleared", stat_rdata[7], 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule